// File: doc/BRIEF.md
# Serial Command Front End for a Quad Wiper Controller

This block is the serial slave that sits in front of a four-channel wiper and data-register bank. A host selects it by pulling chip select low and then clocks bytes in, most significant bit first. The first byte names the device. It carries a fixed device-type nibble, the two address straps, and two zero bits. The second byte carries a 4-bit opcode, a 2-bit data-register select and a 2-bit pot select. Depending on the opcode, the frame then ends, carries one more data byte in either direction, or opens a stepping phase that lasts until chip select rises.

All serial pins are brought into the system clock domain through synchronisers, and edges are detected there. Writes and transfers are handed to the register bank as one command on a valid/ready channel. The command is issued only when chip select rises after a complete frame. `cmd_valid` stays high with a steady payload until `cmd_ready` is seen. If a new frame completes while an earlier command is still waiting, the new command is dropped. Read frames present a selection on `rd_is_dr`/`rd_pot`/`rd_sel` and take the byte from `rd_data`. Increment/decrement steps leave as single-cycle pulses with a direction bit, and these have no back-pressure. A hold input pauses the serial sequence without losing its place.

Top module: `potspi_front`

## Requirements
- R1: SI is sampled on rising SCK edges and SO changes on falling SCK edges, MSB first. The first read-data bit appears after the falling edge that follows the last bit of the instruction byte.
- R2: After reset, no frame is accepted until chip select has been seen going from high to low. Bits clocked while chip select was already low at reset have no effect.
- R3: The identification byte must be 0101 in bits 7:4, equal `strap_addr` in bits 3:2, and be 00 in bits 1:0. On any mismatch, the rest of the frame issues no command, produces no step and leaves SO undriven.
- R4: In the instruction byte, bits 7:4 are the opcode, bits 3:2 the register select and bits 1:0 the pot select. Opcode 1010 writes the wiper and issues `cmd_op`=0. Opcode 1100 writes a data register and issues `cmd_op`=1. Both carry the third byte on `cmd_data`.
- R5: Opcodes 1101 (data register to wiper, `cmd_op`=2), 1110 (wiper to data register, 3), 0001 (all pots, data register to wiper, 4) and 1000 (all pots, wiper to data register, 5) are complete after the instruction byte.
- R6: Opcode 1001 reads the wiper (`rd_is_dr`=0) and opcode 1011 reads a data register (`rd_is_dr`=1). The selected byte is returned on SO and no command is issued.
- R7: Opcode 0101 returns a status byte whose bit 0 is `wip` and whose other bits are 0.
- R8: After opcode 0010, each further rising SCK edge gives one `step_pulse` for the selected pot. `step_up` equals the SI level at that edge. Stepping continues until chip select rises.
- R9: HOLD driven low while SCK is low freezes the shift sequence, and SCK edges are ignored while frozen. HOLD raised while SCK is low resumes the sequence where it stopped. SO is undriven while frozen.
- R10: `so_oe` is high only during the read-data byte of a selected, unfrozen frame.
- R11: A command is issued only when chip select rises after the last bit of a complete frame. A frame cut short is discarded, and undefined opcodes are ignored.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and its payload hold steady. A frame completing in that time is dropped.
- R13: Reset leaves `so_oe`, `cmd_valid` and `step_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| strap_addr | input | 2 | Device address straps |
| so_o | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (tri-state control) |
| rd_is_dr | output | 1 | Read source: 1 data register, 0 wiper |
| rd_pot | output | 2 | Read pot select |
| rd_sel | output | 2 | Read data-register select |
| rd_data | input | 8 | Read byte from the register bank |
| wip | input | 1 | Write-in-progress flag from the bank |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Bank accepts command |
| cmd_op | output | 3 | Command code (see R4, R5) |
| cmd_pot | output | 2 | Command pot select |
| cmd_sel | output | 2 | Command data-register select |
| cmd_data | output | 8 | Write data |
| step_pulse | output | 1 | One wiper step |
| step_up | output | 1 | Step direction, 1 toward high terminal |
| step_pot | output | 2 | Pot being stepped |

## Verification
The bench targets the following failure modes:
- Frames cut off mid-byte: a design that issues on byte count alone would emit a command for them.
- Identification bytes wrong in only one field: a design that checks only the type nibble would answer another device's traffic.
- A pause placed in the middle of a write byte and of a read byte, with SCK toggled during the pause: a design that does not freeze would shift in garbage or skip a read bit.
- The first read bit and the position of the status flag: an off-by-one in the read loader would return a shifted byte.
- Back-pressure on the command channel: a design that changes the payload or overwrites a waiting command would be caught.

// File: rtl/potspi_pkg.sv
package potspi_pkg;
  localparam int BYTE_W = 8;
  localparam int POT_W  = 2;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [3:0] OPC_RD_WIPER  = 4'b1001;
  localparam logic [3:0] OPC_WR_WIPER  = 4'b1010;
  localparam logic [3:0] OPC_RD_DREG   = 4'b1011;
  localparam logic [3:0] OPC_WR_DREG   = 4'b1100;
  localparam logic [3:0] OPC_D2W       = 4'b1101;
  localparam logic [3:0] OPC_W2D       = 4'b1110;
  localparam logic [3:0] OPC_ALL_D2W   = 4'b0001;
  localparam logic [3:0] OPC_ALL_W2D   = 4'b1000;
  localparam logic [3:0] OPC_STEP      = 4'b0010;
  localparam logic [3:0] OPC_STATUS    = 4'b0101;

  typedef enum logic [2:0] {
    CMD_WR_WIPER      = 3'd0,
    CMD_WR_DREG       = 3'd1,
    CMD_DREG_TO_WIPER = 3'd2,
    CMD_WIPER_TO_DREG = 3'd3,
    CMD_ALL_D2W       = 3'd4,
    CMD_ALL_W2D       = 3'd5
  } cmd_op_e;

  typedef enum logic [1:0] {
    RSRC_WIPER  = 2'd0,
    RSRC_DREG   = 2'd1,
    RSRC_STATUS = 2'd2
  } rd_src_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_ID, FR_INSTR, FR_WDATA, FR_RDATA, FR_STEP, FR_DONE, FR_SKIP
  } frame_st_e;

  typedef struct packed {
    cmd_op_e           op;
    logic [POT_W-1:0]  pot;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/potspi_pin_sync.sv
module potspi_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  // STAGES must be at least 2
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/potspi_edge_unit.sv
module potspi_edge_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic cs_act,
  output logic si_s,
  output logic held,
  output logic cs_start,
  output logic cs_stop,
  output logic sck_rise,
  output logic sck_fall
);
  localparam int NPIN = 4;
  // pin order {hold_n, si, sck, cs_n}; cs_n resets to 0 so a low chip
  // select at reset release never looks like a fresh selection
  localparam logic [NPIN-1:0] RST_PAT = 4'b1000;

  logic [NPIN-1:0] raw, syn;
  logic sck_d, cs_d;

  assign raw = {hold_n, si, sck, cs_n};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    potspi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_PAT[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(syn[g])
    );
  end

  assign cs_act = ~syn[0];
  assign si_s   = syn[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
      held  <= 1'b0;
    end else begin
      sck_d <= syn[1];
      cs_d  <= cs_act;
      if (!syn[1]) held <= ~syn[3];
    end
  end

  assign cs_start = cs_act & ~cs_d;
  assign cs_stop  = ~cs_act & cs_d;
  assign sck_rise = syn[1] & ~sck_d & ~held & cs_act;
  assign sck_fall = ~syn[1] & sck_d & ~held & cs_act;
endmodule

// File: rtl/potspi_framer.sv
module potspi_framer
  import potspi_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap,
  input  logic             cs_start,
  input  logic             cs_stop,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             si_s,
  output logic             rd_active,
  output rd_src_e          rd_src,
  output logic [POT_W-1:0] rd_pot,
  output logic [SEL_W-1:0] rd_sel,
  output logic             so_load,
  output logic             so_shift,
  output logic             step_pulse,
  output logic             step_up,
  output logic [POT_W-1:0] step_pot,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output cmd_t             cmd_q
);
  frame_st_e         state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] byte_now;
  logic              byte_end, id_ok, has_cmd, rd_first;
  cmd_t              pend;
  logic [3:0]        opc;

  assign byte_now = {shreg, si_s};
  assign byte_end = (bitcnt == CNT_W'(BYTE_W - 1));
  assign id_ok    = (byte_now[7:4] == DEV_TYPE) && (byte_now[3:2] == strap)
                  && (byte_now[1:0] == 2'b00);
  assign opc      = byte_now[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= FR_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      has_cmd    <= 1'b0;
      rd_first   <= 1'b0;
      rd_src     <= RSRC_WIPER;
      pend       <= '0;
      cmd_q      <= '0;
      cmd_valid  <= 1'b0;
      so_load    <= 1'b0;
      so_shift   <= 1'b0;
      step_pulse <= 1'b0;
      step_up    <= 1'b0;
      step_pot   <= '0;
    end else begin
      step_pulse <= 1'b0;
      so_load    <= 1'b0;
      so_shift   <= 1'b0;
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;

      if (cs_stop) begin
        if (state == FR_DONE && has_cmd && !cmd_valid) begin
          cmd_valid <= 1'b1;
          cmd_q     <= pend;
        end
        state <= FR_IDLE;
      end else if (cs_start) begin
        state   <= FR_ID;
        bitcnt  <= '0;
        has_cmd <= 1'b0;
      end else begin
        if (sck_rise && state != FR_IDLE) begin
          shreg  <= byte_now[BYTE_W-2:0];
          bitcnt <= bitcnt + CNT_W'(1);
          unique case (state)
            FR_ID: if (byte_end) state <= id_ok ? FR_INSTR : FR_SKIP;
            FR_INSTR: if (byte_end) begin
              pend.pot  <= byte_now[1:0];
              pend.sel  <= byte_now[3:2];
              pend.data <= '0;
              case (opc)
                OPC_WR_WIPER: begin pend.op <= CMD_WR_WIPER; state <= FR_WDATA; end
                OPC_WR_DREG:  begin pend.op <= CMD_WR_DREG;  state <= FR_WDATA; end
                OPC_D2W: begin
                  pend.op <= CMD_DREG_TO_WIPER; has_cmd <= 1'b1; state <= FR_DONE;
                end
                OPC_W2D: begin
                  pend.op <= CMD_WIPER_TO_DREG; has_cmd <= 1'b1; state <= FR_DONE;
                end
                OPC_ALL_D2W: begin
                  pend.op <= CMD_ALL_D2W; has_cmd <= 1'b1; state <= FR_DONE;
                end
                OPC_ALL_W2D: begin
                  pend.op <= CMD_ALL_W2D; has_cmd <= 1'b1; state <= FR_DONE;
                end
                OPC_RD_WIPER: begin rd_src <= RSRC_WIPER;  rd_first <= 1'b1; state <= FR_RDATA; end
                OPC_RD_DREG:  begin rd_src <= RSRC_DREG;   rd_first <= 1'b1; state <= FR_RDATA; end
                OPC_STATUS:   begin rd_src <= RSRC_STATUS; rd_first <= 1'b1; state <= FR_RDATA; end
                OPC_STEP:     begin step_pot <= byte_now[1:0]; state <= FR_STEP; end
                default:      state <= FR_SKIP;
              endcase
            end
            FR_WDATA: if (byte_end) begin
              pend.data <= byte_now;
              has_cmd   <= 1'b1;
              state     <= FR_DONE;
            end
            FR_RDATA: if (byte_end) state <= FR_DONE;
            FR_STEP: begin
              step_pulse <= 1'b1;
              step_up    <= si_s;
            end
            default: ;
          endcase
        end
        if (sck_fall && state == FR_RDATA) begin
          if (rd_first) begin
            so_load  <= 1'b1;
            rd_first <= 1'b0;
          end else begin
            so_shift <= 1'b1;
          end
        end
      end
    end
  end

  assign rd_active = (state == FR_RDATA) && !rd_first;
  assign rd_pot    = pend.pot;
  assign rd_sel    = pend.sel;
endmodule

// File: rtl/potspi_so_shift.sv
module potspi_so_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         so_bit
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= din;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end

  assign so_bit = sh[W-1];
endmodule

// File: rtl/potspi_front.sv
module potspi_front
  import potspi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic [1:0]        strap_addr,
  output logic              so_o,
  output logic              so_oe,
  output logic              rd_is_dr,
  output logic [POT_W-1:0]  rd_pot,
  output logic [SEL_W-1:0]  rd_sel,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wip,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [POT_W-1:0]  cmd_pot,
  output logic [SEL_W-1:0]  cmd_sel,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              step_pulse,
  output logic              step_up,
  output logic [POT_W-1:0]  step_pot
);
  logic cs_act, si_s, held, cs_start, cs_stop, sck_rise, sck_fall;
  logic rd_active, so_load, so_shift;
  rd_src_e rd_src;
  cmd_t cmd_q;
  logic [BYTE_W-1:0] rd_byte;

  potspi_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .cs_act(cs_act), .si_s(si_s), .held(held), .cs_start(cs_start),
    .cs_stop(cs_stop), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  potspi_framer #(.DEV_TYPE(DEV_TYPE)) u_framer (
    .clk(clk), .rst_n(rst_n), .strap(strap_addr), .cs_start(cs_start),
    .cs_stop(cs_stop), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
    .rd_active(rd_active), .rd_src(rd_src), .rd_pot(rd_pot), .rd_sel(rd_sel),
    .so_load(so_load), .so_shift(so_shift), .step_pulse(step_pulse),
    .step_up(step_up), .step_pot(step_pot), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_q(cmd_q)
  );

  assign rd_byte = (rd_src == RSRC_STATUS) ? {{(BYTE_W-1){1'b0}}, wip} : rd_data;

  potspi_so_shift #(.W(BYTE_W)) u_so (
    .clk(clk), .rst_n(rst_n), .load(so_load), .shift(so_shift),
    .din(rd_byte), .so_bit(so_o)
  );

  assign so_oe    = cs_act & ~held & rd_active;
  assign rd_is_dr = (rd_src == RSRC_DREG);
  assign cmd_op   = cmd_q.op;
  assign cmd_pot  = cmd_q.pot;
  assign cmd_sel  = cmd_q.sel;
  assign cmd_data = cmd_q.data;
endmodule

// File: rtl/potspi_front_chk.sv
module potspi_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       held,
  input logic       so_oe,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic [1:0] cmd_pot,
  input logic [1:0] cmd_sel,
  input logic [7:0] cmd_data,
  input logic       step_pulse
);
  AST_SO_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !so_oe); // R10
  AST_SO_QUIET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe); // R9
  AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable({cmd_op, cmd_pot, cmd_sel, cmd_data})); // R12
  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse); // R8
  AST_STEP_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> $past(cs_act)); // R8
  AST_CMD_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !$past(cs_act)); // R11
endmodule

bind potspi_front potspi_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .held(held), .so_oe(so_oe),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_pot(cmd_pot), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
  .step_pulse(step_pulse)
);

// File: tb/potspi_front_bench.sv
`timescale 1ns/1ps
module potspi_front_bench;
  localparam int HALF = 6;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] ID_OK = {4'b0101, STRAP, 2'b00};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so_o, so_oe, rd_is_dr, cmd_valid, step_pulse, step_up;
  logic [1:0] rd_pot, rd_sel, cmd_pot, cmd_sel, step_pot;
  logic [7:0] rd_data, cmd_data;
  logic [2:0] cmd_op;
  logic wip = 1'b0, cmd_ready = 1'b1;

  always #4 clk = ~clk;

  potspi_front u_potspi_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .strap_addr(STRAP), .so_o(so_o), .so_oe(so_oe), .rd_is_dr(rd_is_dr),
    .rd_pot(rd_pot), .rd_sel(rd_sel), .rd_data(rd_data), .wip(wip),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
    .step_pulse(step_pulse), .step_up(step_up), .step_pot(step_pot)
  );

  logic [7:0] mdl_wcr [4];
  logic [7:0] mdl_dr  [4][4];
  always_comb rd_data = rd_is_dr ? mdl_dr[rd_pot][rd_sel] : mdl_wcr[rd_pot];

  int n_cmp = 0, n_bad = 0;
  int got_n = 0, up_n = 0, dn_n = 0;
  logic [2:0] last_op; logic [1:0] last_pot, last_sel, last_step_pot;
  logic [7:0] last_data;
  logic last_so, oe_all, oe_any;
  logic [7:0] rx_acc;
  bit finished = 0;

  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      got_n++; last_op = cmd_op; last_pot = cmd_pot; last_sel = cmd_sel; last_data = cmd_data;
    end
    if (rst_n && step_pulse) begin
      if (step_up) up_n++; else dn_n++;
      last_step_pot = step_pot;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b);
    si = b;
    repeat (HALF) @(negedge clk);
    last_so = so_o;
    oe_all &= so_oe; oe_any |= so_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin bit_xfer(v[i]); rx_acc[i] = last_so; end
  endtask

  task automatic frame_start();
    cs_n = 1'b1; repeat (4) @(negedge clk);
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1; repeat (8) @(negedge clk);
  endtask

  function automatic bit is_known(input logic [3:0] o);
    return o inside {4'b1001,4'b1010,4'b1011,4'b1100,4'b1101,4'b1110,4'b0001,4'b1000,4'b0010,4'b0101};
  endfunction

  task automatic run_and_check(input logic [3:0] opc, input logic [1:0] r, input logic [1:0] p,
                               input logic [7:0] d, input int nstep, input logic [15:0] dirs);
    int b_n, b_up, b_dn, e_up;
    logic [7:0] exp_rd;
    b_n = got_n; b_up = up_n; b_dn = dn_n; e_up = 0;
    exp_rd = (opc == 4'b1011) ? mdl_dr[p][r] : (opc == 4'b0101) ? {7'b0, wip} : mdl_wcr[p];
    frame_start();
    send_bits(ID_OK, 7, 0);
    send_bits({opc, r, p}, 7, 0);
    oe_all = 1'b1; oe_any = 1'b0;
    if (opc == 4'b0010) begin
      for (int i = 0; i < nstep; i++) begin bit_xfer(dirs[i]); if (dirs[i]) e_up++; end
    end else if (opc inside {4'b1001,4'b1010,4'b1011,4'b1100,4'b0101} || !is_known(opc)) begin
      send_bits(d, 7, 0);
    end
    frame_end();
    case (opc)
      4'b1010: begin
        chk("R4 wiper write issued", got_n - b_n, 1); chk("R4 op", last_op, 0);
        chk("R4 pot", last_pot, p); chk("R4 data", last_data, d);
        chk("R10 no drive on write", oe_any, 0); mdl_wcr[p] = d;
      end
      4'b1100: begin
        chk("R4 dreg write issued", got_n - b_n, 1); chk("R4 op", last_op, 1);
        chk("R4 pot", last_pot, p); chk("R4 sel", last_sel, r); chk("R4 data", last_data, d);
        mdl_dr[p][r] = d;
      end
      4'b1101: begin
        chk("R5 d2w issued", got_n - b_n, 1); chk("R5 op", last_op, 2);
        chk("R5 pot", last_pot, p); chk("R5 sel", last_sel, r); mdl_wcr[p] = mdl_dr[p][r];
      end
      4'b1110: begin
        chk("R5 w2d issued", got_n - b_n, 1); chk("R5 op", last_op, 3);
        chk("R5 pot", last_pot, p); chk("R5 sel", last_sel, r); mdl_dr[p][r] = mdl_wcr[p];
      end
      4'b0001: begin
        chk("R5 all d2w issued", got_n - b_n, 1); chk("R5 op", last_op, 4); chk("R5 sel", last_sel, r);
        for (int k = 0; k < 4; k++) mdl_wcr[k] = mdl_dr[k][r];
      end
      4'b1000: begin
        chk("R5 all w2d issued", got_n - b_n, 1); chk("R5 op", last_op, 5); chk("R5 sel", last_sel, r);
        for (int k = 0; k < 4; k++) mdl_dr[k][r] = mdl_wcr[k];
      end
      4'b1001, 4'b1011: begin
        chk("R6 read byte on SO (R1 order)", rx_acc, exp_rd);
        chk("R6 read issues nothing", got_n - b_n, 0); chk("R10 drive in read", oe_all, 1);
      end
      4'b0101: begin
        chk("R7 status byte", rx_acc, exp_rd); chk("R10 drive in status", oe_all, 1);
      end
      4'b0010: begin
        chk("R8 up steps", up_n - b_up, e_up); chk("R8 down steps", dn_n - b_dn, nstep - e_up);
        chk("R8 no command", got_n - b_n, 0);
        if (nstep > 0) chk("R8 step pot", last_step_pot, p);
        for (int i = 0; i < nstep; i++)
          if (dirs[i]) begin if (mdl_wcr[p] != 8'hFF) mdl_wcr[p]++; end
          else begin if (mdl_wcr[p] != 8'h00) mdl_wcr[p]--; end
      end
      default: begin
        chk("R11 undefined opcode ignored", got_n - b_n, 0);
        chk("R11 undefined no SO", oe_any, 0);
        chk("R11 undefined no steps", (up_n - b_up) + (dn_n - b_dn), 0);
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int b_n, b_s;
    logic [3:0] opcs [10];
    logic [3:0] bad_opcs [6];
    opcs = '{4'b1001,4'b1010,4'b1011,4'b1100,4'b1101,4'b1110,4'b0001,4'b1000,4'b0010,4'b0101};
    bad_opcs = '{4'b0000,4'b0011,4'b0100,4'b0110,4'b0111,4'b1111};
    void'($urandom(32'd20240918));
    for (int p = 0; p < 4; p++) begin
      mdl_wcr[p] = 8'($urandom);
      for (int r = 0; r < 4; r++) mdl_dr[p][r] = 8'($urandom);
    end
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 so_oe after reset", so_oe, 0);
    chk("R13 cmd_valid after reset", cmd_valid, 0);
    chk("R13 step_pulse after reset", step_pulse, 0);

    // R2: chip select low since reset, never toggled
    b_n = got_n;
    send_bits(ID_OK, 7, 0); send_bits({4'b1010, 2'b00, 2'b01}, 7, 0); send_bits(8'h77, 7, 0);
    frame_end();
    chk("R2 no command before first selection", got_n - b_n, 0);

    // directed per opcode
    run_and_check(4'b1010, 2'b00, 2'd3, 8'hA5, 0, 16'h0);
    run_and_check(4'b1001, 2'b00, 2'd3, 8'h00, 0, 16'h0);
    run_and_check(4'b1100, 2'd2, 2'd1, 8'h3C, 0, 16'h0);
    run_and_check(4'b1011, 2'd2, 2'd1, 8'h00, 0, 16'h0);
    run_and_check(4'b1101, 2'd2, 2'd1, 8'h00, 0, 16'h0);
    run_and_check(4'b1110, 2'd3, 2'd0, 8'h00, 0, 16'h0);
    run_and_check(4'b0001, 2'd1, 2'd0, 8'h00, 0, 16'h0);
    run_and_check(4'b1000, 2'd0, 2'd0, 8'h00, 0, 16'h0);
    wip = 1'b1; run_and_check(4'b0101, 2'd0, 2'd0, 8'h00, 0, 16'h0);
    wip = 1'b0; run_and_check(4'b0101, 2'd0, 2'd0, 8'h00, 0, 16'h0);
    run_and_check(4'b0010, 2'd0, 2'd2, 8'h00, 7, 16'b0010110);
    run_and_check(4'b0000, 2'd0, 2'd0, 8'h55, 0, 16'h0);

    // R3: each ID field wrong
    for (int v = 0; v < 3; v++) begin
      logic [7:0] bad_id;
      bad_id = (v == 0) ? {4'b0110, STRAP, 2'b00} : (v == 1) ? {4'b0101, ~STRAP, 2'b00}
                                                             : {4'b0101, STRAP, 2'b01};
      b_n = got_n; b_s = up_n + dn_n;
      frame_start(); send_bits(bad_id, 7, 0); send_bits({4'b1010, 4'b0000}, 7, 0);
      oe_any = 1'b0; send_bits(8'h11, 7, 0); frame_end();
      chk("R3 foreign ID write ignored", got_n - b_n, 0);
      frame_start(); send_bits(bad_id, 7, 0); send_bits({4'b1001, 4'b0000}, 7, 0);
      oe_any = 1'b0; send_bits(8'h00, 7, 0); frame_end();
      chk("R3 foreign ID read leaves SO off", oe_any, 0);
      frame_start(); send_bits(bad_id, 7, 0); send_bits({4'b0010, 4'b0001}, 7, 0);
      send_bits(8'hF0, 7, 0); frame_end();
      chk("R3 foreign ID no steps", up_n + dn_n - b_s, 0);
    end

    // R11: truncated frames
    b_n = got_n;
    frame_start(); send_bits(ID_OK, 7, 0); send_bits({4'b1010, 4'b0001}, 7, 0);
    send_bits(8'hC3, 7, 3); frame_end();
    chk("R11 short write discarded", got_n - b_n, 0);
    frame_start(); send_bits(ID_OK, 7, 0); send_bits({4'b1101, 4'b0101}, 7, 2); frame_end();
    chk("R11 short transfer discarded", got_n - b_n, 0);

    // R9: hold in a write data byte, SCK toggled while held
    b_n = got_n;
    frame_start(); send_bits(ID_OK, 7, 0); send_bits({4'b1010, 4'b0000}, 7, 0);
    send_bits(8'h5A, 7, 4);
    hold_n = 1'b0; repeat (HALF) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      si = ~si; sck = 1'b1; repeat (HALF) @(negedge clk); sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    hold_n = 1'b1; repeat (HALF) @(negedge clk);
    send_bits(8'h5A, 3, 0); frame_end();
    chk("R9 write across hold issued", got_n - b_n, 1);
    chk("R9 write across hold data", last_data, 8'h5A);
    mdl_wcr[0] = 8'h5A;

    // R9: hold in a read byte
    frame_start(); send_bits(ID_OK, 7, 0); send_bits({4'b1011, 2'd1, 2'd2}, 7, 0);
    send_bits(8'h00, 7, 5);
    hold_n = 1'b0; repeat (HALF) @(negedge clk);
    chk("R9 SO off while held", so_oe, 0);
    sck = 1'b1; repeat (HALF) @(negedge clk); sck = 1'b0; repeat (HALF) @(negedge clk);
    hold_n = 1'b1; repeat (HALF) @(negedge clk);
    chk("R9 SO back after resume", so_oe, 1);
    send_bits(8'h00, 4, 0); frame_end();
    chk("R9 read across hold", rx_acc, mdl_dr[2][1]);

    // R12: back-pressure and drop of a second command
    cmd_ready = 1'b0; b_n = got_n;
    frame_start(); send_bits(ID_OK, 7, 0); send_bits({4'b1010, 4'b0001}, 7, 0);
    send_bits(8'h96, 7, 0); frame_end();
    repeat (10) @(negedge clk);
    chk("R12 valid held under back-pressure", cmd_valid, 1);
    chk("R12 payload held", cmd_data, 8'h96);
    frame_start(); send_bits(ID_OK, 7, 0); send_bits({4'b1010, 4'b0001}, 7, 0);
    send_bits(8'h21, 7, 0); frame_end();
    chk("R12 waiting payload unchanged", cmd_data, 8'h96);
    cmd_ready = 1'b1; repeat (4) @(negedge clk);
    chk("R12 exactly one accepted", got_n - b_n, 1);
    chk("R12 accepted data", last_data, 8'h96);
    chk("R12 nothing left waiting", cmd_valid, 0);
    mdl_wcr[1] = 8'h96;

    // random frames
    for (int n = 0; n < 60; n++) begin
      int k;
      logic [3:0] o; logic [1:0] rr, pp;
      k = $urandom_range(0, 11);
      o = (k < 10) ? opcs[k] : bad_opcs[$urandom_range(0, 5)];
      rr = 2'($urandom); pp = 2'($urandom);
      if (o == 4'b0001 || o == 4'b1000) pp = 2'd0;
      wip = 1'($urandom);
      run_and_check(o, rr, pp, 8'($urandom), $urandom_range(1, 16), 16'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule